// File: doc/BRIEF.md
# Three-Wire Serial Control Slave with Status Readback

This block is the register access port of a larger chip. An external controller selects it by pulling `cs_n` low and clocks a 16-bit command word in on `sdi` with `sck`. The first bit says whether the word is a write or a read. The next seven bits hold a register address, and the last eight bits hold data. The block takes `cs_n`, `sck` and `sdi` into its own clock domain through synchronizers and finds their edges there. A write is applied to the internal configuration registers only when `cs_n` returns high, and only if the frame is complete. The registers are presented on a flat output bus for the rest of the chip.

While the last eight bits of a frame are clocked in, the block shifts a byte out on `sdo`, most significant bit first. A control register at address `CTRL_ADDR` chooses what that byte is. Bit 3 of that register enables automatic readback, and bits 2:0 select one status byte.

- With automatic readback on, any write frame returns the selected status byte.
- With automatic readback off, a read frame returns the addressed register directly.

Only the three fixed identity registers and the status bytes are readable. The status bytes arrive from the rest of the chip on `stat_bytes`. A write to address 0 restores every configuration register to its default value.

Top module: `ctrl3w_slave`

## Requirements
- R1: While `cs_n` is low, `sdi` is shifted in on each rising edge of `sck`. Bit 15 of the word, sent first, is the direction flag (0 = write, 1 = read). Bits 14:8 are the address and bits 7:0 are the data.
- R2: A write frame (flag 0) to an address from 3 to `NREG`-1 stores its data byte in `cfg_regs[8*addr +: 8]`. The register keeps its old value until `cs_n` rises.
- R3: A frame in which `cs_n` rises after fewer than 16 `sck` rising edges changes no register. Rising edges beyond the sixteenth are ignored.
- R4: `sdo_oe` is 0 whenever `cs_n` is high and 1 whenever `cs_n` is low.
- R5: The returned byte appears on `sdo` most significant bit first. Bit 7 is valid after the `sck` fall that follows the 8th rising edge. Each later bit is valid after the following fall, so every bit can be sampled at the next rising edge.
- R6: When bit 3 of the register at `CTRL_ADDR` is 1 and the frame is a write, the returned byte is the status byte selected by bits 2:0 of that register. Code k (0 to 6) returns `stat_bytes[8k+7:8k]`, and code 7 returns 0x00. The control value in force before the frame is the one used.
- R7: When bit 3 of the control register is 0 and the frame is a read, the returned byte depends on the address:
  - address 0 returns 0x05;
  - address 1 returns 0x88;
  - address 2 returns {4'b0, `REV`};
  - address `STAT_BASE`+k (k from 0 to 6) returns status byte k;
  - every other address returns 0x00.
- R8: The other two combinations return 0x00: automatic readback with a read frame, and direct mode with a write frame.
- R9: A complete write frame to address 0 sets every configuration register to its default value, which is 0x00.
- R10: Write frames to addresses 1, 2 or `NREG` and above change nothing. Read frames never change a register.
- R11: After reset, `cfg_regs` is all zero and `sdo` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Frame select, active low |
| sck | input | 1 | Serial bit clock |
| sdi | input | 1 | Serial command input |
| stat_bytes | input | NSTAT*8 | Status bytes from the chip; byte k is selector code k |
| sdo | output | 1 | Serial readback data |
| sdo_oe | output | 1 | Output enable for the `sdo` pad |
| cfg_regs | output | NREG*8 | Configuration registers; byte a is address a |

## Verification
Each pin passes through two synchronizer flops and one edge-detect register before it acts. A result therefore follows its pin event by three to four `clk` cycles:
- a write becomes visible on `cfg_regs` about four cycles after `cs_n` rises;
- a new `sdo` bit appears about four cycles after `sck` falls.

The bench holds each `sck` phase for eight `clk` cycles. It samples `sdo` at the end of the low phase, just before the next rising edge, and it reads `cfg_regs` ten cycles after `cs_n` rises. It also compares the registers just before `cs_n` rises, which shows that no write lands early. The bench sweeps every address with a direct read, writes every writable address, and tries all eight selector codes.

// File: rtl/ctrl3w_pkg.sv
package ctrl3w_pkg;
    localparam int WORD_W = 16;
    localparam int ADDR_W = 7;
    localparam int DATA_W = 8;
    localparam int HEAD_W = WORD_W - DATA_W;
    localparam int CNT_W  = $clog2(WORD_W + 1);

    typedef struct packed {
        logic              cs_prev;
        logic              sck_prev;
        logic [CNT_W-1:0]  cnt;
        logic [WORD_W-1:0] sh;
        logic [DATA_W-1:0] out;
    } frame_t;
endpackage

// File: rtl/ctrl3w_sync.sv
module ctrl3w_sync #(
    parameter int               LANES   = 3,
    parameter int               STAGES  = 2,
    parameter logic [LANES-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LANES-1:0] pin_i,
    output logic [LANES-1:0] lvl_o
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [STAGES-1:0] pipe_q;
        logic [STAGES-1:0] pipe_d;

        always_comb begin
            if (STAGES > 1) pipe_d = {pipe_q[STAGES-2:0], pin_i[g]};
            else            pipe_d = pin_i[g];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe_q <= {STAGES{RST_VAL[g]}};
            else        pipe_q <= pipe_d;
        end

        assign lvl_o[g] = pipe_q[STAGES-1];
    end
endmodule

// File: rtl/ctrl3w_regs.sv
module ctrl3w_regs #(
    parameter int NREG     = 32,
    parameter int ADDR_W   = 7,
    parameter int DATA_W   = 8,
    parameter int FIRST_RW = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [DATA_W-1:0]        wr_data,
    output logic [NREG*DATA_W-1:0]   cfg_o
);
    localparam logic [NREG*DATA_W-1:0] DEFAULTS = '0;

    logic [NREG*DATA_W-1:0] cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            if (wr_addr == '0) begin
                cfg_d = DEFAULTS;
            end else if (int'(wr_addr) >= FIRST_RW && int'(wr_addr) < NREG) begin
                cfg_d[int'(wr_addr)*DATA_W +: DATA_W] = wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= DEFAULTS;
        else        cfg_q <= cfg_d;
    end

    assign cfg_o = cfg_q;

    // R9
    soft_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == '0) |=> (cfg_q == DEFAULTS));

    // R10
    ro_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (int'(wr_addr) == 1 || int'(wr_addr) == 2 || int'(wr_addr) >= NREG))
        |=> $stable(cfg_q));
endmodule

// File: rtl/ctrl3w_rdsel.sv
module ctrl3w_rdsel #(
    parameter int         ADDR_W    = 7,
    parameter int         DATA_W    = 8,
    parameter int         NSTAT     = 7,
    parameter int         STAT_BASE = 16,
    parameter logic [3:0] REV       = 4'h1
) (
    input  logic                      is_read,
    input  logic [ADDR_W-1:0]         addr,
    input  logic                      auto_en,
    input  logic [2:0]                sel,
    input  logic [NSTAT*DATA_W-1:0]   stat,
    output logic [DATA_W-1:0]         byte_o
);
    localparam logic [DATA_W-1:0] ID_LO = DATA_W'(8'h05);
    localparam logic [DATA_W-1:0] ID_HI = DATA_W'(8'h88);

    always_comb begin
        byte_o = '0;
        if (auto_en && !is_read) begin
            if (int'(sel) < NSTAT) byte_o = stat[int'(sel)*DATA_W +: DATA_W];
        end else if (!auto_en && is_read) begin
            if (int'(addr) == 0)      byte_o = ID_LO;
            else if (int'(addr) == 1) byte_o = ID_HI;
            else if (int'(addr) == 2) byte_o = DATA_W'(REV);
            else if (int'(addr) >= STAT_BASE && int'(addr) < STAT_BASE + NSTAT)
                byte_o = stat[(int'(addr) - STAT_BASE)*DATA_W +: DATA_W];
        end
    end
endmodule

// File: rtl/ctrl3w_slave.sv
module ctrl3w_slave
    import ctrl3w_pkg::*;
#(
    parameter int         NREG      = 32,
    parameter int         CTRL_ADDR = 9,
    parameter int         STAT_BASE = 16,
    parameter int         NSTAT     = 7,
    parameter logic [3:0] REV       = 4'h1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cs_n,
    input  logic                      sck,
    input  logic                      sdi,
    input  logic [NSTAT*DATA_W-1:0]   stat_bytes,
    output logic                      sdo,
    output logic                      sdo_oe,
    output logic [NREG*DATA_W-1:0]    cfg_regs
);
    localparam int AUTO_BIT = CTRL_ADDR*DATA_W + 3;
    localparam int SEL_LSB  = CTRL_ADDR*DATA_W;

    logic [2:0] lvl;
    logic       cs_lvl, sck_lvl, sdi_lvl;
    logic       cs_fall, cs_rise, sck_rise, sck_fall;
    logic       wr_en;
    logic [DATA_W-1:0] rd_byte;
    frame_t q, d;

    ctrl3w_sync #(.LANES(3), .STAGES(2), .RST_VAL(3'b001)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_i ({sdi, sck, cs_n}),
        .lvl_o (lvl)
    );

    assign cs_lvl   = lvl[0];
    assign sck_lvl  = lvl[1];
    assign sdi_lvl  = lvl[2];
    assign cs_fall  =  q.cs_prev & ~cs_lvl;
    assign cs_rise  = ~q.cs_prev &  cs_lvl;
    assign sck_rise = ~q.sck_prev &  sck_lvl & ~cs_lvl;
    assign sck_fall =  q.sck_prev & ~sck_lvl & ~cs_lvl;

    assign wr_en = cs_rise && (q.cnt == CNT_W'(WORD_W)) && !q.sh[WORD_W-1];

    ctrl3w_rdsel #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NSTAT(NSTAT),
        .STAT_BASE(STAT_BASE), .REV(REV)
    ) u_rdsel (
        .is_read (q.sh[HEAD_W-1]),
        .addr    (q.sh[ADDR_W-1:0]),
        .auto_en (cfg_regs[AUTO_BIT]),
        .sel     (cfg_regs[SEL_LSB +: 3]),
        .stat    (stat_bytes),
        .byte_o  (rd_byte)
    );

    ctrl3w_regs #(
        .NREG(NREG), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .FIRST_RW(3)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (q.sh[WORD_W-2 -: ADDR_W]),
        .wr_data (q.sh[DATA_W-1:0]),
        .cfg_o   (cfg_regs)
    );

    always_comb begin
        d = q;
        d.cs_prev  = cs_lvl;
        d.sck_prev = sck_lvl;
        if (cs_fall) begin
            d.cnt = '0;
            d.sh  = '0;
            d.out = '0;
        end else begin
            if (sck_rise && q.cnt < CNT_W'(WORD_W)) begin
                d.sh  = {q.sh[WORD_W-2:0], sdi_lvl};
                d.cnt = q.cnt + 1'b1;
            end
            if (sck_fall && q.cnt >= CNT_W'(HEAD_W) && q.cnt < CNT_W'(WORD_W)) begin
                if (q.cnt == CNT_W'(HEAD_W)) d.out = rd_byte;
                else                         d.out = {q.out[DATA_W-2:0], 1'b0};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q          <= '0;
            q.cs_prev  <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign sdo    = q.out[DATA_W-1];
    assign sdo_oe = ~cs_n;

    // R5
    sdo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sck_fall && !cs_fall) |=> $stable(sdo));

    // R3
    short_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_rise && q.cnt != CNT_W'(WORD_W)) |=> $stable(cfg_regs));

    // R1
    cnt_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.cnt == CNT_W'(WORD_W) && !cs_fall) |=> (q.cnt == CNT_W'(WORD_W)));
endmodule

// File: tb/tb_ctrl3w_slave.sv
module tb_ctrl3w_slave;
    localparam int NREG = 32, CTRL = 9, SBASE = 16, NSTAT = 7;

    logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sck = 1'b0, sdi = 1'b0;
    logic [NSTAT*8-1:0] stat_bytes;
    logic sdo, sdo_oe;
    logic [NREG*8-1:0] cfg_regs;

    int tests = 0, fails = 0;
    bit done = 0;
    logic [7:0] cfg_m [NREG];

    always #2.5 clk = ~clk;

    ctrl3w_slave dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sdi(sdi),
        .stat_bytes(stat_bytes), .sdo(sdo), .sdo_oe(sdo_oe), .cfg_regs(cfg_regs)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [7:0] exp_rd(input logic w, input logic [6:0] a);
        logic       auto_en = cfg_m[CTRL][3];
        logic [2:0] sel     = cfg_m[CTRL][2:0];
        if (auto_en && !w) return (sel < NSTAT) ? stat_bytes[sel*8 +: 8] : 8'h00;
        if (!auto_en && w) begin
            if (a == 0) return 8'h05;
            if (a == 1) return 8'h88;
            if (a == 2) return 8'h01;
            if (a >= SBASE && a < SBASE + NSTAT) return stat_bytes[(a - SBASE)*8 +: 8];
        end
        return 8'h00;
    endfunction

    task automatic cfg_cmp(input string tag);
        bit ok = 1;
        int bad = 0;
        for (int i = 0; i < NREG; i++) begin
            if (cfg_regs[i*8 +: 8] !== cfg_m[i]) begin
                ok = 0;
                bad = i;
            end
        end
        chk(ok, tag, int'(cfg_regs[bad*8 +: 8]), int'(cfg_m[bad]));
    endtask

    task automatic xfer(input logic [15:0] word, input int nbits);
        logic [7:0] got = 8'h00;
        logic [7:0] exp = exp_rd(word[15], word[14:8]);
        string tag;
        if (cfg_m[CTRL][3] && !word[15])      tag = "R6 status byte";
        else if (!cfg_m[CTRL][3] && word[15]) tag = "R7 direct read";
        else                                  tag = "R8 idle combination";
        cs_n = 1'b0;
        waitc(8);
        chk(sdo_oe === 1'b1, "R4 oe while selected", int'(sdo_oe), 1);
        for (int i = 0; i < nbits; i++) begin
            sdi = (i < 16) ? word[15 - i] : 1'b1;
            waitc(8);
            if (i >= 8 && i < 16) got[15 - i] = sdo;
            sck = 1'b1;
            waitc(8);
            sck = 1'b0;
        end
        waitc(8);
        cfg_cmp("R2 no commit before cs_n rise");
        cs_n = 1'b1;
        waitc(1);
        chk(sdo_oe === 1'b0, "R4 oe released", int'(sdo_oe), 0);
        waitc(10);
        if (nbits >= 16) begin
            chk(got === exp, {tag, " / R5 msb first"}, int'(got), int'(exp));
            if (!word[15]) begin
                if (word[14:8] == 0) begin
                    for (int r = 0; r < NREG; r++) cfg_m[r] = 8'h00;
                end else if (word[14:8] >= 3 && word[14:8] < NREG) begin
                    cfg_m[word[14:8]] = word[7:0];
                end
            end
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < NSTAT; k++) stat_bytes[k*8 +: 8] = 8'(8'h31 + k*8'h17);
        for (int r = 0; r < NREG; r++) cfg_m[r] = 8'h00;
        waitc(4);
        rst_n = 1'b1;
        waitc(4);
        // R11 reset state
        cfg_cmp("R11 reset cfg");
        chk(sdo === 1'b0, "R11 reset sdo", int'(sdo), 0);
        chk(sdo_oe === 1'b0, "R4 oe idle", int'(sdo_oe), 0);

        // R7 direct read sweep over every address, data bits nonzero
        for (int a = 0; a < 128; a++) xfer({1'b1, 7'(a), 8'hA5}, 16);
        cfg_cmp("R10 read frames never write");

        // R2 write every writable address (R8: direct write returns 0)
        for (int a = 3; a < NREG; a++) begin
            xfer({1'b0, 7'(a), 8'(a*7 + 3)}, 16);
            cfg_cmp("R2 write lands");
        end

        // R10 read-only and out-of-range addresses
        xfer({1'b0, 7'd1, 8'hFF}, 16);
        xfer({1'b0, 7'd2, 8'hFF}, 16);
        xfer({1'b0, 7'd32, 8'hFF}, 16);
        xfer({1'b0, 7'd127, 8'hFF}, 16);
        cfg_cmp("R10 ignored addresses");

        // R3 short frames and extra bits
        xfer({1'b0, 7'd4, 8'hFF}, 8);
        xfer({1'b0, 7'd4, 8'hFF}, 15);
        cfg_cmp("R3 short frame dropped");
        xfer({1'b0, 7'd6, 8'h3C}, 19);
        cfg_cmp("R3 extra bits ignored");

        // R6 every selector code in automatic mode
        for (int s = 0; s < 8; s++) begin
            xfer({1'b0, 7'(CTRL), 8'(8'h08 | s)}, 16);
            xfer({1'b0, 7'd5, 8'(s)}, 16);
            xfer({1'b1, 7'd0, 8'h00}, 16);
        end
        // R6 new status values
        for (int k = 0; k < NSTAT; k++) stat_bytes[k*8 +: 8] = 8'(8'hC4 ^ (k*8'h29));
        xfer({1'b0, 7'(CTRL), 8'h0B}, 16);
        xfer({1'b0, 7'd7, 8'h11}, 16);
        cfg_cmp("R2 write in automatic mode");

        // R9 soft reset
        xfer({1'b0, 7'd0, 8'h77}, 16);
        cfg_cmp("R9 soft reset defaults");
        xfer({1'b1, 7'd0, 8'h00}, 16);
        xfer({1'b1, 7'(SBASE + 6), 8'h00}, 16);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule